// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event sources into a sticky 16-bit status word and combines it with a 16-bit mask into one level-sensitive interrupt line. Eight general event inputs and three single-cycle pulses from a real-time-clock unit set their status bits directly. The three clock pulses are a periodic tick, an alarm match and an update error. A push-button level input is synchronised and edge-detected inside the block, and each press sets one status bit.

Software reaches the block through a byte-wide register port: an address, write data, a write strobe and combinational read data. The block is written in place of a serial-bus target. The mask is written one byte at a time. The status word is read-only. Pending bits are cleared by writing ones to one of two acknowledge byte registers, one for each half of the status word.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the mask is 0x0FFF, the status word is 0x0000 and irq_o is low.
- R2: irq_o is high exactly when some bit of (status AND NOT mask) is set. It follows a mask write, an acknowledge write or an event in the cycle after the clock edge that takes it.
- R3: Register address 0 holds mask bits 7:0 and address 1 holds mask bits 15:8. A write to either address replaces only its own byte. Both addresses read back the current mask byte.
- R4: A write to address 4 clears status bits 7:0 wherever the written byte has a one. A write to address 5 does the same for status bits 15:8. Bits written as zero keep their value, and status bits that are not cleared stay set.
- R5: Address 2 reads status bits 7:0 and address 3 reads status bits 15:8. Addresses 4 and 5 read as zero, as do addresses 6 and 7. Writes to addresses 2, 3, 6 and 7 change no state.
- R6: A low-to-high transition on pwr_btn_i sets status bit 11 on the third rising clock edge after the edge that first samples the high level. While the input stays high, the bit is not set again.
- R7: A pulse on evt_i[n] sets status bit n. A pulse on rtc_tick_i sets bit 8, rtc_alarm_i sets bit 9 and rtc_err_i sets bit 10. Each bit stays set until it is acknowledged.
- R8: When an event and an acknowledge of the same bit arrive in the same cycle, the bit is left set.
- R9: Status bits 15:12 have no source and always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | General event set pulses, one for each status bit 7:0 |
| rtc_tick_i | input | 1 | Periodic clock tick pulse (status bit 8) |
| rtc_alarm_i | input | 1 | Alarm match pulse (status bit 9) |
| rtc_err_i | input | 1 | Clock update error pulse (status bit 10) |
| pwr_btn_i | input | 1 | Asynchronous push-button level (status bit 11 on a rising edge) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after a status bit that is set and acknowledged in the same cycle. A design that lets the clear win loses the event, so the status read shows the bit as zero. It writes each mask byte alone and then reads the other byte back. A design that writes the full word, or the wrong byte, changes the other half or fails to change the addressed half. It holds the push-button input high across an acknowledge. Level detection in place of edge detection sets bit 11 again, and a wrong synchroniser depth moves the first set away from the third edge. It also writes to the read-only and unused addresses, which must leave the status word and the interrupt line as they were.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned N_LANE    = STAT_W / BYTE_W;
  localparam int unsigned REG_AW    = 3;
  // register map: each base is followed by N_LANE byte lanes
  localparam int unsigned MASK_BASE = 0;
  localparam int unsigned STAT_BASE = 2;
  localparam int unsigned ACK_BASE  = 4;
  // fixed source positions
  localparam int unsigned TICK_BIT  = 8;
  localparam int unsigned ALARM_BIT = 9;
  localparam int unsigned ERR_BIT   = 10;
  localparam int unsigned BTN_BIT   = 11;
endpackage

// File: rtl/irq_btn_edge.sv
module irq_btn_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], lvl_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_BTN_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/irq_stat_bits.sv
module irq_stat_bits #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[b] <= 1'b0;
      else if (set_i[b]) stat_q[b] <= 1'b1;   // set beats clear
      else if (clr_i[b]) stat_q[b] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i))); // R7
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned          N_LANE = 2,
  parameter int unsigned          LANE_W = 8,
  parameter logic [N_LANE*LANE_W-1:0] RST_VAL = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LANE-1:0]          we_i,
  input  logic [LANE_W-1:0]          wdata_i,
  output logic [N_LANE*LANE_W-1:0]   mask_o
);
  logic [N_LANE*LANE_W-1:0] mask_q;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q[l*LANE_W +: LANE_W] <= RST_VAL[l*LANE_W +: LANE_W];
      else if (we_i[l]) mask_q[l*LANE_W +: LANE_W] <= wdata_i;
    end

    AST_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[l] |=> $stable(mask_q[l*LANE_W +: LANE_W])); // R3
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned       N_EVT       = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [STAT_W-1:0] MASK_RST    = 16'h0FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              rtc_tick_i,
  input  logic              rtc_alarm_i,
  input  logic              rtc_err_i,
  input  logic              pwr_btn_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_LANE-1:0] mask_we, ack_we;
  logic [STAT_W-1:0] set_vec, clr_vec, stat, mask;
  logic              btn_rise;

  irq_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pwr_btn_i),
    .rise_o (btn_rise)
  );

  always_comb begin
    for (int l = 0; l < N_LANE; l++) begin
      mask_we[l] = wr_i && (int'(addr_i) == MASK_BASE + l);
      ack_we[l]  = wr_i && (int'(addr_i) == ACK_BASE + l);
      clr_vec[l*BYTE_W +: BYTE_W] = ack_we[l] ? wdata_i : '0;
    end
  end

  always_comb begin
    set_vec            = '0;
    set_vec[N_EVT-1:0] = evt_i;
    set_vec[TICK_BIT]  = rtc_tick_i;
    set_vec[ALARM_BIT] = rtc_alarm_i;
    set_vec[ERR_BIT]   = rtc_err_i;
    set_vec[BTN_BIT]   = btn_rise;
  end

  irq_stat_bits #(.W(STAT_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .stat_o (stat)
  );

  irq_mask_reg #(.N_LANE(N_LANE), .LANE_W(BYTE_W), .RST_VAL(MASK_RST)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < N_LANE; l++) begin
      if (int'(addr_i) == MASK_BASE + l) rdata_o = mask[l*BYTE_W +: BYTE_W];
      if (int'(addr_i) == STAT_BASE + l) rdata_o = stat[l*BYTE_W +: BYTE_W];
    end
  end

  assign irq_o = |(stat & ~mask);

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i)); // R2
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((set_vec != '0) || (mask_we != '0))); // R2
endmodule

// File: tb/irq_status_agg_tb_top.sv
module irq_status_agg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       tick = 1'b0, alarm = 1'b0, err = 1'b0, btn = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_status_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rtc_tick_i(tick),
    .rtc_alarm_i(alarm), .rtc_err_i(err), .pwr_btn_i(btn),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_stat, m_mask;
  int bq[$];

  always @(posedge clk) begin
    int set_m, clr_m;
    if (!rst_n) begin
      m_stat = 0; m_mask = 'h0FFF; bq = '{0, 0, 0, 0};
    end else begin
      bq.push_back(int'(btn)); void'(bq.pop_front());
      set_m = int'(evt) | (int'(tick) << 8) | (int'(alarm) << 9) | (int'(err) << 10);
      if (bq[1] == 1 && bq[0] == 0) set_m = set_m | (1 << 11);
      clr_m = 0;
      if (wr && addr == 4) clr_m = int'(wdata);
      if (wr && addr == 5) clr_m = int'(wdata) << 8;
      if (wr && addr == 0) m_mask = (m_mask & 'hFF00) | int'(wdata);
      if (wr && addr == 1) m_mask = (m_mask & 'h00FF) | (int'(wdata) << 8);
      m_stat = ((m_stat & ~clr_m) | set_m) & 'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== ((m_stat & ~m_mask & 'hFFFF) != 0)) begin
        errors++;
        $display("FAIL R2 irq per-cycle actual %0b expected %0b", irq, ((m_stat & ~m_mask & 'hFFFF) != 0));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); addr = 3'(a); #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic wrt(input int a, input int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse(input int e, input bit t, input bit al, input bit er);
    @(negedge clk); evt = 8'(e); tick = t; alarm = al; err = er;
    @(negedge clk); evt = '0; tick = 0; alarm = 0; err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 'hFF, "R1 mask lo");
    rd(1, 'h0F, "R1 mask hi");
    rd(2, 0, "R1 stat lo");
    rd(3, 0, "R1 stat hi");
    chk("R1 irq", int'(irq), 0);

    // R7 masked events are recorded
    pulse('h05, 0, 0, 0);
    rd(2, 'h05, "R7 evt sticky");
    chk("R2 masked irq low", int'(irq), 0);

    // R3 / R2 mask lanes
    wrt(0, 'hFE);
    chk("R2 irq after unmask", int'(irq), 1);
    rd(0, 'hFE, "R3 mask lo written");
    rd(1, 'h0F, "R3 mask hi kept");
    wrt(1, 'hF0);
    rd(1, 'hF0, "R3 mask hi written");
    rd(0, 'hFE, "R3 mask lo kept");

    // R4 acknowledge low
    wrt(4, 'h01);
    chk("R4 irq after ack", int'(irq), 0);
    rd(2, 'h04, "R4 ack lo partial");
    wrt(4, 'h00);
    rd(2, 'h04, "R4 ack zero byte");

    // R7 clock sources
    pulse(0, 1, 0, 0);
    rd(3, 'h01, "R7 tick bit8");
    pulse(0, 0, 1, 0);
    rd(3, 'h03, "R7 alarm bit9");
    pulse(0, 0, 0, 1);
    rd(3, 'h07, "R7 err bit10");
    chk("R2 irq from hi", int'(irq), 1);
    wrt(5, 'h07);
    rd(3, 'h00, "R4 ack hi");

    // R6 button edge, timing and hold
    @(negedge clk); addr = 3; btn = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R6 not before third edge", int'(rdata), 0);
    @(negedge clk); #1;
    chk("R6 set on third edge", int'(rdata), 'h08);
    wrt(5, 'h08);
    repeat (8) @(negedge clk);
    rd(3, 'h00, "R6 held level no reset");
    @(negedge clk); btn = 1'b0;
    repeat (4) @(negedge clk);
    btn = 1'b1;
    repeat (5) @(negedge clk);
    rd(3, 'h08, "R6 second press");
    btn = 1'b0;
    wrt(5, 'h08);

    // R8 set and ack same cycle
    @(negedge clk); evt = 'h08; addr = 4; wdata = 'h0C; wr = 1'b1;
    @(negedge clk); evt = '0; wr = 1'b0;
    rd(2, 'h08, "R8 set beats ack");

    // R5 read-only and unused addresses
    rd(4, 0, "R5 ack lo reads zero");
    rd(5, 0, "R5 ack hi reads zero");
    rd(6, 0, "R5 addr6 zero");
    rd(7, 0, "R5 addr7 zero");
    wrt(2, 'h00);
    wrt(3, 'hFF);
    wrt(6, 'hFF);
    wrt(7, 'hFF);
    rd(2, 'h08, "R5 stat lo unchanged");
    rd(3, 'h00, "R5 stat hi unchanged");
    rd(0, 'hFE, "R5 mask lo unchanged");

    // R9 unused bits
    wrt(1, 'h00);
    pulse('hFF, 1, 1, 1);
    rd(3, 'h07, "R9 bits 15:12 zero");

    // mixed patterns against the model
    for (int i = 0; i < 16; i++) begin
      pulse((i * 37) & 'hFF, i[0], i[1], 0);
      wrt(4, (i * 91) & 'hFF);
      if (i[2]) wrt(0, (i * 53) & 'hFF);
      rd(2, m_stat & 'hFF, "R4 R7 mixed lo");
      rd(3, (m_stat >> 8) & 'hFF, "R7 mixed hi");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule